// File: doc/BRIEF.md
# Digital Voltage Window Monitor

This block watches a digitized sense voltage and reports whether it has left a window around a programmable reference. Every value is an unsigned integer in millivolts. A 5-bit select code picks one of 32 evenly spaced reference levels between a programmable low endpoint and high endpoint. The code is inverted, so the all-ones code gives the low endpoint and the all-zeros code gives the high endpoint.

The undervoltage trip point is the threshold input. The overvoltage trip point is that threshold reflected about the reference, so the two trip points sit the same distance from it. Both comparators have hysteresis equal to one tenth of that distance. The overvoltage and undervoltage flags are registered.

A persistence timer qualifies the undervoltage flag. A delayed-undervoltage flag rises only when the undervoltage has held for a programmed number of clock cycles without a break. Any break in the undervoltage restarts the timer. The block uses integer arithmetic only. The reset is asynchronous and active-low, and it is expected to be released synchronously to the clock.

Top module: `vwin_monitor`

## Requirements
- R1: The reference is lo + floor((31 − code) × (hi − lo) / 31). Code 5'b11111 gives exactly lo and code 5'b00000 gives exactly hi. The relation holds when hi ≥ lo.
- R2: The undervoltage trip point equals the threshold input. The overvoltage trip point is ref + (ref − threshold). When the threshold is at or above the reference, the distance is taken as 0 and the overvoltage trip point equals the reference.
- R3: Hysteresis is floor(distance / 10), where distance = ref − threshold. For example, a distance of 51 gives 5.
- R4: The `ov` output is 1 in the cycle after a sample with sense > overvoltage trip point. It stays 1 while sense ≥ trip − hysteresis.
- R5: The `ov` output returns to 0 in the cycle after a sample with sense < overvoltage trip point − hysteresis.
- R6: The `uv` output is 1 in the cycle after a sample with sense < threshold. It returns to 0 in the cycle after a sample with sense > threshold + hysteresis, and holds its value when sense is between these two points.
- R7: With a delay setting of D > 0, `uvd` rises exactly D clock cycles after the cycle in which `uv` first reads 1, provided `uv` stays 1 throughout.
- R8: With a delay setting of 0, `uvd` is 1 in every cycle in which `uv` is 1.
- R9: `uvd` is 0 in any cycle in which `uv` is 0. When `uv` falls, the timer restarts, so a later undervoltage needs the full D cycles again.
- R10: While `rst_n` is 0, `ov`, `uv` and `uvd` are 0 and the timer is cleared. After release, a new undervoltage needs the full D cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_mv | input | 13 | Sense voltage sample, mV |
| sel_code | input | 5 | Inverted reference select code |
| lo_mv | input | 13 | Low endpoint of reference range, mV |
| hi_mv | input | 13 | High endpoint of reference range, mV |
| uvth_mv | input | 13 | Undervoltage threshold, mV |
| dly_cycles | input | 16 | Undervoltage persistence delay, cycles |
| ov | output | 1 | Overvoltage flag |
| uv | output | 1 | Undervoltage flag |
| uvd | output | 1 | Delayed undervoltage flag |

## Verification
On every cycle the assertions check several properties. The reference stays inside its range and hits each endpoint for the extreme codes. Each flag sets and clears on the cycle after the sample that crosses its hysteresis bound. `uvd` never stands without `uv`, follows `uv` at once when the delay is zero, and cannot appear in the first undervoltage cycle when the delay is nonzero.

Some behaviour needs the bench's scenarios instead. These include the exact integer values of the reference, the mirrored trip point and the truncated hysteresis. They also include the exact cycle count to `uvd`, the restart after an interrupted undervoltage, and the cleared timer after a reset in mid-count. The bench shows these by sweeping sense values to just either side of each bound and by counting cycles.

// File: rtl/vwin_pkg.sv
package vwin_pkg;
  localparam int unsigned VW_MV_W   = 13;
  localparam int unsigned VW_CODE_W = 5;
  localparam int unsigned VW_DLY_W  = 16;
  localparam int unsigned VW_HYST_NUM = 1;
  localparam int unsigned VW_HYST_DEN = 10;

  typedef enum logic {
    CMP_ABOVE = 1'b0,
    CMP_BELOW = 1'b1
  } cmp_dir_e;
endpackage

// File: rtl/vwin_thresholds.sv
module vwin_thresholds #(
  parameter int unsigned MV_W     = vwin_pkg::VW_MV_W,
  parameter int unsigned CODE_W   = vwin_pkg::VW_CODE_W,
  parameter int unsigned HYST_NUM = vwin_pkg::VW_HYST_NUM,
  parameter int unsigned HYST_DEN = vwin_pkg::VW_HYST_DEN
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [MV_W-1:0]   lo_i,
  input  logic [MV_W-1:0]   hi_i,
  input  logic [MV_W-1:0]   uvth_i,
  output logic [MV_W-1:0]   ref_o,
  output logic [MV_W:0]     ov_trip_o,
  output logic [MV_W:0]     uv_trip_o,
  output logic [MV_W:0]     hyst_o
);
  localparam int unsigned STEPS  = (1 << CODE_W) - 1;
  localparam int unsigned PROD_W = MV_W + CODE_W;
  localparam int unsigned TW     = MV_W + 1;
  localparam int unsigned HW     = TW + 8;

  logic [MV_W-1:0]   span;
  logic [CODE_W-1:0] idx;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;
  logic [TW-1:0]     delta;

  // Inverted code: all-ones selects the low end, all-zeros the high end.
  always_comb begin
    span  = (hi_i >= lo_i) ? (hi_i - lo_i) : '0;
    idx   = CODE_W'(STEPS) - code_i;
    prod  = PROD_W'(idx) * PROD_W'(span);
    quot  = prod / PROD_W'(STEPS);
    ref_o = MV_W'(PROD_W'(lo_i) + quot);
  end

  // Mirrored window about the reference, hysteresis scaled by half-width.
  always_comb begin
    delta     = (uvth_i < ref_o) ? TW'(ref_o - uvth_i) : '0;
    ov_trip_o = TW'(ref_o) + delta;
    uv_trip_o = TW'(uvth_i);
    hyst_o    = TW'((HW'(delta) * HW'(HYST_NUM)) / HW'(HYST_DEN));
  end
endmodule

// File: rtl/vwin_hyst_cmp.sv
module vwin_hyst_cmp #(
  parameter int unsigned       W   = vwin_pkg::VW_MV_W + 1,
  parameter vwin_pkg::cmp_dir_e DIR = vwin_pkg::CMP_ABOVE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample_i,
  input  logic [W-1:0] trip_i,
  input  logic [W-1:0] hyst_i,
  output logic         flag_o
);
  logic set_cond;
  logic clr_cond;
  logic flag_d;
  logic flag_q;

  generate
    if (DIR == vwin_pkg::CMP_ABOVE) begin : g_above
      // Trip above the point, release below point minus hysteresis.
      always_comb begin
        set_cond = (sample_i > trip_i);
        clr_cond = (sample_i < (trip_i - hyst_i));
      end
    end else begin : g_below
      // Trip below the point, release above point plus hysteresis.
      always_comb begin
        set_cond = (sample_i < trip_i);
        clr_cond = (sample_i > (trip_i + hyst_i));
      end
    end
  endgenerate

  always_comb begin
    flag_d = flag_q ? ~clr_cond : set_cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/vwin_persist_timer.sv
module vwin_persist_timer #(
  parameter int unsigned DLY_W = vwin_pkg::VW_DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uv_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             uvd_o
);
  logic [DLY_W-1:0] cnt_d;
  logic [DLY_W-1:0] cnt_q;
  logic             cnt_inc;
  logic             cnt_ld;

  always_comb begin
    cnt_inc = uv_i && (cnt_q < dly_i);
    cnt_ld  = ~uv_i | cnt_inc;
    if (!uv_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + DLY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ld) begin
      cnt_q <= cnt_d;
    end
  end

  assign uvd_o = uv_i && (cnt_q >= dly_i);

  AST_UVD_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(uvd_o) && (dly_i != '0)) |-> $past(uv_i)); // R7
endmodule

// File: rtl/vwin_monitor.sv
module vwin_monitor #(
  parameter int unsigned MV_W   = vwin_pkg::VW_MV_W,
  parameter int unsigned CODE_W = vwin_pkg::VW_CODE_W,
  parameter int unsigned DLY_W  = vwin_pkg::VW_DLY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MV_W-1:0]   sense_mv,
  input  logic [CODE_W-1:0] sel_code,
  input  logic [MV_W-1:0]   lo_mv,
  input  logic [MV_W-1:0]   hi_mv,
  input  logic [MV_W-1:0]   uvth_mv,
  input  logic [DLY_W-1:0]  dly_cycles,
  output logic              ov,
  output logic              uv,
  output logic              uvd
);
  localparam int unsigned TW = MV_W + 1;

  logic [MV_W-1:0] ref_mv;
  logic [TW-1:0]   ov_trip;
  logic [TW-1:0]   uv_trip;
  logic [TW-1:0]   hyst;
  logic [TW-1:0]   sense_x;

  assign sense_x = TW'(sense_mv);

  vwin_thresholds #(.MV_W(MV_W), .CODE_W(CODE_W)) i_thr (
    .code_i    (sel_code),
    .lo_i      (lo_mv),
    .hi_i      (hi_mv),
    .uvth_i    (uvth_mv),
    .ref_o     (ref_mv),
    .ov_trip_o (ov_trip),
    .uv_trip_o (uv_trip),
    .hyst_o    (hyst)
  );

  vwin_hyst_cmp #(.W(TW), .DIR(vwin_pkg::CMP_ABOVE)) i_ov_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sense_x),
    .trip_i   (ov_trip),
    .hyst_i   (hyst),
    .flag_o   (ov)
  );

  vwin_hyst_cmp #(.W(TW), .DIR(vwin_pkg::CMP_BELOW)) i_uv_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sense_x),
    .trip_i   (uv_trip),
    .hyst_i   (hyst),
    .flag_o   (uv)
  );

  vwin_persist_timer #(.DLY_W(DLY_W)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .uv_i  (uv),
    .dly_i (dly_cycles),
    .uvd_o (uvd)
  );

  AST_REF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_mv >= lo_mv) |-> ((ref_mv >= lo_mv) && (ref_mv <= hi_mv))); // R1
  AST_REF_LOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_code == '1) |-> (ref_mv == lo_mv)); // R1
  AST_REF_HIGH_END: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_code == '0) && (hi_mv >= lo_mv)) |-> (ref_mv == hi_mv)); // R1
  AST_OV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ov && (sense_x > ov_trip)) |=> ov); // R4
  AST_OV_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ov && (sense_x < (ov_trip - hyst))) |=> !ov); // R5
  AST_UV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv && (sense_x < uv_trip)) |=> uv); // R6
  AST_UV_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (uv && (sense_x > (uv_trip + hyst))) |=> !uv); // R6
  AST_UVD_NEEDS_UV: assert property (@(posedge clk) disable iff (!rst_n)
    uvd |-> uv); // R9
  AST_UVD_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (uv && (dly_cycles == '0)) |-> uvd); // R8
endmodule

// File: tb/test_vwin_monitor.sv
`timescale 1ns/1ps
module test_vwin_monitor;
  logic        clk;
  logic        rst_n;
  logic [12:0] sense_mv;
  logic [4:0]  sel_code;
  logic [12:0] lo_mv;
  logic [12:0] hi_mv;
  logic [12:0] uvth_mv;
  logic [15:0] dly_cycles;
  logic        ov;
  logic        uv;
  logic        uvd;

  int checks;
  int fails;
  bit done;

  typedef struct packed {
    logic [4:0]  code;
    logic [12:0] lo;
    logic [12:0] hi;
    logic [12:0] uvth;
    logic [12:0] sense;
    logic        exp_ov;
    logic        exp_uv;
  } vec_t;

  localparam int NV = 26;
  // A: ref 1500, ov trip 1700, hyst 20. B: ref 1000 (code all ones), ov 1100, hyst 10.
  // C: ref 2550 (code all zeros), ov 3050, hyst 50. D: ref 851, ov 902, hyst 5.
  // E: threshold above ref, distance 0, ov trip 1000, hyst 0.
  localparam vec_t VECS [NV] = '{
    '{5'd21, 13'd1000, 13'd2550, 13'd1300, 13'd1500, 1'b0, 1'b0},
    '{5'd21, 13'd1000, 13'd2550, 13'd1300, 13'd1700, 1'b0, 1'b0},
    '{5'd21, 13'd1000, 13'd2550, 13'd1300, 13'd1701, 1'b1, 1'b0},
    '{5'd21, 13'd1000, 13'd2550, 13'd1300, 13'd1680, 1'b1, 1'b0},
    '{5'd21, 13'd1000, 13'd2550, 13'd1300, 13'd1679, 1'b0, 1'b0},
    '{5'd21, 13'd1000, 13'd2550, 13'd1300, 13'd1300, 1'b0, 1'b0},
    '{5'd21, 13'd1000, 13'd2550, 13'd1300, 13'd1299, 1'b0, 1'b1},
    '{5'd21, 13'd1000, 13'd2550, 13'd1300, 13'd1320, 1'b0, 1'b1},
    '{5'd21, 13'd1000, 13'd2550, 13'd1300, 13'd1321, 1'b0, 1'b0},
    '{5'd31, 13'd1000, 13'd2550, 13'd900,  13'd1101, 1'b1, 1'b0},
    '{5'd31, 13'd1000, 13'd2550, 13'd900,  13'd1095, 1'b1, 1'b0},
    '{5'd31, 13'd1000, 13'd2550, 13'd900,  13'd899,  1'b0, 1'b1},
    '{5'd31, 13'd1000, 13'd2550, 13'd900,  13'd905,  1'b0, 1'b1},
    '{5'd0,  13'd1000, 13'd2550, 13'd2050, 13'd2100, 1'b0, 1'b1},
    '{5'd0,  13'd1000, 13'd2550, 13'd2050, 13'd2101, 1'b0, 1'b0},
    '{5'd0,  13'd1000, 13'd2550, 13'd2050, 13'd3051, 1'b1, 1'b0},
    '{5'd0,  13'd1000, 13'd2550, 13'd2050, 13'd3000, 1'b1, 1'b0},
    '{5'd0,  13'd1000, 13'd2550, 13'd2050, 13'd2999, 1'b0, 1'b0},
    '{5'd15, 13'd800,  13'd900,  13'd800,  13'd902,  1'b0, 1'b0},
    '{5'd15, 13'd800,  13'd900,  13'd800,  13'd903,  1'b1, 1'b0},
    '{5'd15, 13'd800,  13'd900,  13'd800,  13'd897,  1'b1, 1'b0},
    '{5'd15, 13'd800,  13'd900,  13'd800,  13'd896,  1'b0, 1'b0},
    '{5'd31, 13'd1000, 13'd2550, 13'd1200, 13'd1100, 1'b1, 1'b1},
    '{5'd31, 13'd1000, 13'd2550, 13'd1200, 13'd1000, 1'b1, 1'b1},
    '{5'd31, 13'd1000, 13'd2550, 13'd1200, 13'd1201, 1'b1, 1'b0},
    '{5'd31, 13'd1000, 13'd2550, 13'd1200, 13'd999,  1'b0, 1'b1}
  };

  vwin_monitor i_vwin_monitor (
    .clk        (clk),
    .rst_n      (rst_n),
    .sense_mv   (sense_mv),
    .sel_code   (sel_code),
    .lo_mv      (lo_mv),
    .hi_mv      (hi_mv),
    .uvth_mv    (uvth_mv),
    .dly_cycles (dly_cycles),
    .ov         (ov),
    .uv         (uv),
    .uvd        (uvd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg_a();
    sel_code = 5'd21; lo_mv = 13'd1000; hi_mv = 13'd2550; uvth_mv = 13'd1300;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0;
    set_cfg_a();
    sense_mv = 13'd1500;
    dly_cycles = 16'd60000;
    repeat (3) @(negedge clk);
    check("R10 reset ov", 32'(ov), 0);
    check("R10 reset uv", 32'(uv), 0);
    check("R10 reset uvd", 32'(uvd), 0);
    rst_n = 1'b1;

    // Table: R1 R2 R3 via trip boundaries, R4 R5 on ov, R6 on uv.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sel_code = VECS[i].code;
      lo_mv    = VECS[i].lo;
      hi_mv    = VECS[i].hi;
      uvth_mv  = VECS[i].uvth;
      sense_mv = VECS[i].sense;
      @(negedge clk);
      check($sformatf("R1 R2 R3 R4 R5 ov row %0d", i), 32'(ov), 32'(VECS[i].exp_ov));
      check($sformatf("R1 R2 R3 R6 uv row %0d", i), 32'(uv), 32'(VECS[i].exp_uv));
    end

    // R7: persistence count of 5 cycles.
    @(negedge clk);
    set_cfg_a();
    sense_mv = 13'd1500;
    dly_cycles = 16'd5;
    repeat (2) @(negedge clk);
    check("R7 idle uv", 32'(uv), 0);
    sense_mv = 13'd1000;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 1) check("R7 uv asserted", 32'(uv), 1);
      check($sformatf("R7 uvd cycle %0d", i), 32'(uvd), (i == 6) ? 1 : 0);
    end

    // R9: uv falls, uvd drops in the same cycle.
    sense_mv = 13'd1500;
    @(negedge clk);
    check("R9 uv low", 32'(uv), 0);
    check("R9 uvd low with uv", 32'(uvd), 0);

    // R9: interrupted episode restarts the timer.
    sense_mv = 13'd1000;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      check($sformatf("R9 short episode uvd %0d", i), 32'(uvd), 0);
    end
    sense_mv = 13'd1500;
    @(negedge clk);
    check("R9 break uv", 32'(uv), 0);
    sense_mv = 13'd1000;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      check($sformatf("R9 restart uvd cycle %0d", i), 32'(uvd), (i == 6) ? 1 : 0);
    end

    // R8: zero delay gives uvd with uv.
    sense_mv = 13'd1500;
    @(negedge clk);
    dly_cycles = 16'd0;
    sense_mv = 13'd1000;
    @(negedge clk);
    check("R8 uv", 32'(uv), 1);
    check("R8 uvd immediate", 32'(uvd), 1);

    // R10: reset mid-episode clears flags and timer.
    dly_cycles = 16'd3;
    repeat (4) @(negedge clk);
    check("R10 pre-reset uvd", 32'(uvd), 1);
    rst_n = 1'b0;
    #1;
    check("R10 async ov", 32'(ov), 0);
    check("R10 async uv", 32'(uv), 0);
    check("R10 async uvd", 32'(uvd), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check($sformatf("R10 timer cleared uvd cycle %0d", i), 32'(uvd), (i == 4) ? 1 : 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule